// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit virtual address into a physical address by reading two entries from page tables held in memory. A root register holds the frame number of the top-level directory. When a request is accepted, the walker copies that root and the virtual address, then reads the directory entry. If that entry is present, it reads an entry from the second-level table the directory points at. The result is the frame from the second entry joined with the untouched 12-bit page offset.

A client sends one translation at a time over a valid/ready request channel. It gets back the physical address, or a fault marker that says which level had a missing entry, over a valid/ready response channel. Memory is reached through a single read port. That port has a request handshake and a response-valid strobe, and the response may come back any number of cycles later. Software or a context-switch sequencer loads the root register through a write strobe. The walker does no caching of translations. It has no large-page support and updates no permission or status bits.

Top module: `ptw_walker`

## Requirements
- R1: While reset is held and right after it is released, `req_ready_o` is 1, and both `mem_req_valid_o` and `rsp_valid_o` are 0.
- R2: The first memory read of a walk goes to address {root[19:0], va[31:22], 2'b00}, where root is the root register value at acceptance.
- R3: The second memory read is issued only after the first read's response has come back. It goes to address {dir_entry[31:12], va[21:12], 2'b00}.
- R4: When both entries have bit 0 set, the response has `rsp_fault_o`=0 and `rsp_paddr_o` = {table_entry[31:12], va[11:0]}.
- R5: When the directory entry has bit 0 clear, the walk makes exactly one memory read. It responds with `rsp_fault_o`=1 and `rsp_fault_lvl_o`=0.
- R6: When the table entry has bit 0 clear, the walk makes exactly two memory reads. It responds with `rsp_fault_o`=1 and `rsp_fault_lvl_o`=1.
- R7: A root write in the same cycle as request acceptance, or during a walk, does not change that walk's directory address. The new value is used by the next accepted request.
- R8: `req_ready_o` is 0 from the cycle after acceptance until the response handshake completes, so only one walk is ever in flight.
- R9: While `mem_req_valid_o` is 1 and `mem_req_ready_i` is 0, the request stays asserted with a stable address. Any response latency of one cycle or more is accepted.
- R10: While `rsp_valid_o` is 1 and `rsp_ready_i` is 0, the response stays asserted and its address and fault fields stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| root_we_i | input | 1 | Root register write strobe |
| root_ppn_i | input | 20 | New directory frame number |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Walker idle, request accepted |
| req_vaddr_i | input | 32 | Virtual address to translate |
| mem_req_valid_o | output | 1 | Memory read request valid |
| mem_req_ready_i | input | 1 | Memory accepts read request |
| mem_req_addr_o | output | 32 | Entry address to read |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 32 | Entry read from memory |
| rsp_valid_o | output | 1 | Translation result valid |
| rsp_ready_i | input | 1 | Client accepts result |
| rsp_paddr_o | output | 32 | Physical address |
| rsp_fault_o | output | 1 | Entry not present |
| rsp_fault_lvl_o | output | 1 | Faulting level: 0 directory, 1 table |

## Verification
A root register write and the acceptance of a new request can land on the same clock edge. The walker must then use the root value from before the write, and the next walk must use the new one. The bench provokes this by raising the write strobe and the request valid in the same cycle. It judges the result by the address of the first memory read of that walk and of the walk after it. A second case writes the root while the walk is stalled on memory, and it is judged the same way.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int VA_W   = 32;
  localparam int PA_W   = 32;
  localparam int OFF_W  = 12;
  localparam int IDX_W  = 10;
  localparam int PTE_W  = 32;
  localparam int PPN_W  = PA_W - OFF_W;
  localparam int ENT_SH = OFF_W - IDX_W;  // byte offset bits of a 4-byte entry

  typedef enum logic [2:0] {
    ST_IDLE, ST_DIR_REQ, ST_DIR_WAIT, ST_TBL_REQ, ST_TBL_WAIT, ST_RESP
  } walk_st_e;

  typedef enum logic {LVL_DIR = 1'b0, LVL_TBL = 1'b1} walk_lvl_e;
endpackage

// File: rtl/ptw_root_reg.sv
module ptw_root_reg
  import ptw_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [PPN_W-1:0] wdata_i,
  output logic [PPN_W-1:0] root_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   root_o <= '0;
    else if (we_i) root_o <= wdata_i;
  end
endmodule

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr
  import ptw_pkg::*;
(
  input  walk_lvl_e        lvl_i,
  input  logic [PPN_W-1:0] root_ppn_i,
  input  logic [PPN_W-1:0] tbl_ppn_i,
  input  logic [VA_W-1:0]  vaddr_i,
  output logic [PA_W-1:0]  addr_o
);
  logic [PPN_W-1:0] base;
  logic [IDX_W-1:0] idx;

  always_comb begin
    if (lvl_i == LVL_TBL) begin
      base = tbl_ppn_i;
      idx  = vaddr_i[OFF_W +: IDX_W];
    end else begin
      base = root_ppn_i;
      idx  = vaddr_i[VA_W-1 -: IDX_W];
    end
    addr_o = {base, idx, {ENT_SH{1'b0}}};
  end
endmodule

// File: rtl/ptw_walk_fsm.sv
module ptw_walk_fsm
  import ptw_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [VA_W-1:0]  req_vaddr_i,
  input  logic [PPN_W-1:0] root_ppn_i,
  output logic             mem_req_valid_o,
  input  logic             mem_req_ready_i,
  input  logic             mem_rsp_valid_i,
  input  logic [PTE_W-1:0] mem_rsp_data_i,
  output logic             rsp_valid_o,
  input  logic             rsp_ready_i,
  output logic [PA_W-1:0]  rsp_paddr_o,
  output logic             rsp_fault_o,
  output logic             rsp_fault_lvl_o,
  output walk_lvl_e        lvl_o,
  output logic [PPN_W-1:0] walk_root_o,
  output logic [PPN_W-1:0] next_ppn_o,
  output logic [VA_W-1:0]  vaddr_o
);
  walk_st_e         st_q, st_d;
  logic [VA_W-1:0]  va_q;
  logic [PPN_W-1:0] root_q, next_q;
  logic             fault_q;
  walk_lvl_e        flvl_q;
  logic             pte_ok, waiting;
  logic             unused_pte;

  assign pte_ok     = mem_rsp_data_i[0];
  assign waiting    = (st_q == ST_DIR_WAIT) || (st_q == ST_TBL_WAIT);
  assign unused_pte = ^mem_rsp_data_i[PTE_W-PPN_W-1:1];

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:     if (req_valid_i)     st_d = ST_DIR_REQ;
      ST_DIR_REQ:  if (mem_req_ready_i) st_d = ST_DIR_WAIT;
      ST_DIR_WAIT: if (mem_rsp_valid_i) st_d = pte_ok ? ST_TBL_REQ : ST_RESP;
      ST_TBL_REQ:  if (mem_req_ready_i) st_d = ST_TBL_WAIT;
      ST_TBL_WAIT: if (mem_rsp_valid_i) st_d = ST_RESP;
      ST_RESP:     if (rsp_ready_i)     st_d = ST_IDLE;
      default:                          st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      va_q    <= '0;
      root_q  <= '0;
      next_q  <= '0;
      fault_q <= 1'b0;
      flvl_q  <= LVL_DIR;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && req_valid_i) begin
        va_q    <= req_vaddr_i;
        root_q  <= root_ppn_i;  // snapshot: later root writes do not reach this walk
        fault_q <= 1'b0;
        flvl_q  <= LVL_DIR;
      end
      if (waiting && mem_rsp_valid_i) begin
        next_q <= mem_rsp_data_i[PTE_W-1 -: PPN_W];
        if (!pte_ok) begin
          fault_q <= 1'b1;
          flvl_q  <= (st_q == ST_TBL_WAIT) ? LVL_TBL : LVL_DIR;
        end
      end
    end
  end

  assign req_ready_o     = (st_q == ST_IDLE);
  assign mem_req_valid_o = (st_q == ST_DIR_REQ) || (st_q == ST_TBL_REQ);
  assign rsp_valid_o     = (st_q == ST_RESP);
  assign rsp_paddr_o     = {next_q, va_q[OFF_W-1:0]};
  assign rsp_fault_o     = fault_q;
  assign rsp_fault_lvl_o = flvl_q;
  assign lvl_o           = (st_q == ST_TBL_REQ) ? LVL_TBL : LVL_DIR;
  assign walk_root_o     = root_q;
  assign next_ppn_o      = next_q;
  assign vaddr_o         = va_q;
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             root_we_i,
  input  logic [PPN_W-1:0] root_ppn_i,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [VA_W-1:0]  req_vaddr_i,
  output logic             mem_req_valid_o,
  input  logic             mem_req_ready_i,
  output logic [PA_W-1:0]  mem_req_addr_o,
  input  logic             mem_rsp_valid_i,
  input  logic [PTE_W-1:0] mem_rsp_data_i,
  output logic             rsp_valid_o,
  input  logic             rsp_ready_i,
  output logic [PA_W-1:0]  rsp_paddr_o,
  output logic             rsp_fault_o,
  output logic             rsp_fault_lvl_o
);
  logic [PPN_W-1:0] root_cur, walk_root, next_ppn;
  logic [VA_W-1:0]  walk_va;
  walk_lvl_e        lvl;

  ptw_root_reg u_root (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (root_we_i),
    .wdata_i(root_ppn_i),
    .root_o (root_cur)
  );

  ptw_walk_fsm u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .req_valid_i    (req_valid_i),
    .req_ready_o    (req_ready_o),
    .req_vaddr_i    (req_vaddr_i),
    .root_ppn_i     (root_cur),
    .mem_req_valid_o(mem_req_valid_o),
    .mem_req_ready_i(mem_req_ready_i),
    .mem_rsp_valid_i(mem_rsp_valid_i),
    .mem_rsp_data_i (mem_rsp_data_i),
    .rsp_valid_o    (rsp_valid_o),
    .rsp_ready_i    (rsp_ready_i),
    .rsp_paddr_o    (rsp_paddr_o),
    .rsp_fault_o    (rsp_fault_o),
    .rsp_fault_lvl_o(rsp_fault_lvl_o),
    .lvl_o          (lvl),
    .walk_root_o    (walk_root),
    .next_ppn_o     (next_ppn),
    .vaddr_o        (walk_va)
  );

  ptw_entry_addr u_addr (
    .lvl_i     (lvl),
    .root_ppn_i(walk_root),
    .tbl_ppn_i (next_ppn),
    .vaddr_i   (walk_va),
    .addr_o    (mem_req_addr_o)
  );
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk
  import ptw_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic            req_ready_o,
  input logic [VA_W-1:0] req_vaddr_i,
  input logic            mem_req_valid_o,
  input logic            mem_req_ready_i,
  input logic [PA_W-1:0] mem_req_addr_o,
  input logic            mem_rsp_valid_i,
  input logic            rsp_valid_o,
  input logic            rsp_ready_i,
  input logic [PA_W-1:0] rsp_paddr_o,
  input logic            rsp_fault_o,
  input logic            rsp_fault_lvl_o
);
  logic [VA_W-1:0] va_q;
  logic [1:0]      n_rd, n_rsp;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      va_q  <= '0;
      n_rd  <= '0;
      n_rsp <= '0;
    end else if (req_valid_i && req_ready_o) begin
      va_q  <= req_vaddr_i;
      n_rd  <= '0;
      n_rsp <= '0;
    end else begin
      if (mem_req_valid_o && mem_req_ready_i && n_rd != 2'd3) n_rd <= n_rd + 2'd1;
      if (mem_rsp_valid_i && n_rsp != 2'd3) n_rsp <= n_rsp + 2'd1;
    end
  end

  a_r8_single_walk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o || rsp_valid_o) |-> !req_ready_o);

  a_r9_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));

  a_r10_rsp_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=>
      (rsp_valid_o && $stable(rsp_paddr_o) && $stable(rsp_fault_o) && $stable(rsp_fault_lvl_o)));

  a_r2_dir_index: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && n_rd == 2'd0) |-> mem_req_addr_o[OFF_W-1:ENT_SH] == va_q[VA_W-1 -: IDX_W]);

  a_r3_tbl_index: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && n_rd == 2'd1) |-> mem_req_addr_o[OFF_W-1:ENT_SH] == va_q[OFF_W +: IDX_W]);

  a_r3_dependent_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && n_rd == 2'd1) |-> n_rsp != 2'd0);

  a_r4_offset_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_fault_o) |-> rsp_paddr_o[OFF_W-1:0] == va_q[OFF_W-1:0]);

  a_r5_dir_fault_one_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o && !rsp_fault_lvl_o) |-> n_rd == 2'd1);

  a_r6_tbl_fault_two_reads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o && rsp_fault_lvl_o) |-> n_rd == 2'd2);
endmodule

bind ptw_walker ptw_walker_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_valid_i    (req_valid_i),
  .req_ready_o    (req_ready_o),
  .req_vaddr_i    (req_vaddr_i),
  .mem_req_valid_o(mem_req_valid_o),
  .mem_req_ready_i(mem_req_ready_i),
  .mem_req_addr_o (mem_req_addr_o),
  .mem_rsp_valid_i(mem_rsp_valid_i),
  .rsp_valid_o    (rsp_valid_o),
  .rsp_ready_i    (rsp_ready_i),
  .rsp_paddr_o    (rsp_paddr_o),
  .rsp_fault_o    (rsp_fault_o),
  .rsp_fault_lvl_o(rsp_fault_lvl_o)
);

// File: tb/ptw_walker_tb_top.sv
module ptw_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        root_we;
  logic [19:0] root_ppn;
  logic        req_valid, req_ready;
  logic [31:0] req_vaddr;
  logic        mem_req_valid, mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        rsp_valid, rsp_ready;
  logic [31:0] rsp_paddr;
  logic        rsp_fault, rsp_fault_lvl;

  always #5 clk = ~clk;

  ptw_walker dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .root_we_i(root_we), .root_ppn_i(root_ppn),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_vaddr_i(req_vaddr),
    .mem_req_valid_o(mem_req_valid), .mem_req_ready_i(mem_req_ready),
    .mem_req_addr_o(mem_req_addr), .mem_rsp_valid_i(mem_rsp_valid),
    .mem_rsp_data_i(mem_rsp_data), .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready),
    .rsp_paddr_o(rsp_paddr), .rsp_fault_o(rsp_fault), .rsp_fault_lvl_o(rsp_fault_lvl)
  );

  int checks = 0;
  int failures = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model
  logic [31:0] mem_m [logic [31:0]];
  int          mem_stall = 0;
  int          mem_lat = 1;
  int          rd_cnt = 0;
  logic [31:0] rd_addr [4];

  initial begin
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        logic [31:0] a;
        repeat (mem_stall) @(negedge clk);
        a = mem_req_addr;
        if (rd_cnt < 4) rd_addr[rd_cnt] = a;
        rd_cnt++;
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        repeat (mem_lat - 1) @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem_m.exists(a) ? mem_m[a] : 32'h0;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
      end
    end
  end

  typedef struct packed {
    logic [31:0] root;
    logic [31:0] va;
    logic [31:0] dir_e;
    logic [31:0] tbl_e;
    logic [31:0] pa;
    logic        fault;
    logic        lvl;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VEC_TBL [NV] = '{
    '{32'h0001_0000, 32'h1234_5678, 32'h0002_0001, 32'hABCD_E003, 32'hABCD_E678, 1'b0, 1'b0},
    '{32'h7FFF_F000, 32'hFFFF_FFFF, 32'h0000_3001, 32'h0000_0001, 32'h0000_0FFF, 1'b0, 1'b0},
    '{32'h0003_0000, 32'h0040_1000, 32'h0000_5000, 32'h0000_0000, 32'h0000_0000, 1'b1, 1'b0},
    '{32'h0004_0000, 32'h0000_0ABC, 32'h0000_6001, 32'hFFFF_F000, 32'h0000_0000, 1'b1, 1'b1},
    '{32'h0040_0000, 32'h0000_0000, 32'h0000_8001, 32'h1234_5FFF, 32'h1234_5000, 1'b0, 1'b0}
  };

  function automatic logic [31:0] dir_addr(input logic [31:0] root, input logic [31:0] va);
    return {root[31:12], va[31:22], 2'b00};
  endfunction

  function automatic logic [31:0] tbl_addr(input logic [31:0] dir_e, input logic [31:0] va);
    return {dir_e[31:12], va[21:12], 2'b00};
  endfunction

  task automatic set_root(input logic [31:0] root);
    @(negedge clk);
    root_we = 1'b1; root_ppn = root[31:12];
    @(negedge clk);
    root_we = 1'b0;
  endtask

  task automatic load_tables(input logic [31:0] root, input logic [31:0] va,
                             input logic [31:0] dir_e, input logic [31:0] tbl_e);
    mem_m.delete();
    mem_m[dir_addr(root, va)] = dir_e;
    mem_m[tbl_addr(dir_e, va)] = tbl_e;
  endtask

  // wr_mode: 0 none, 1 root write in the acceptance cycle, 2 root write mid-walk
  task automatic walk(input logic [31:0] va, input int hold, input int wr_mode,
                      input logic [31:0] wr_root, output logic [31:0] pa,
                      output logic f, output logic l);
    int busy_bad = 0;
    int hold_bad = 0;
    rd_cnt = 0;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va;
    if (wr_mode == 1) begin root_we = 1'b1; root_ppn = wr_root[31:12]; end
    @(negedge clk);
    req_valid = 1'b0; root_we = 1'b0;
    if (wr_mode == 2) begin root_we = 1'b1; root_ppn = wr_root[31:12]; end
    for (int i = 0; i < 200; i++) begin
      if (rsp_valid) break;
      if (req_ready) busy_bad++;
      @(negedge clk);
      root_we = 1'b0;
    end
    chk(busy_bad == 0, "R8 ready low while busy", busy_bad, 0);
    chk(rsp_valid, "R8 response arrives", {31'b0, rsp_valid}, 1);
    pa = rsp_paddr; f = rsp_fault; l = rsp_fault_lvl;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      if (!rsp_valid || rsp_paddr != pa || rsp_fault != f || rsp_fault_lvl != l) hold_bad++;
    end
    if (hold > 0) chk(hold_bad == 0, "R10 response held", hold_bad, 0);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(req_ready && !rsp_valid, "R8 idle after response", {30'b0, req_ready, rsp_valid}, 32'h2);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog R8 actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] pa;
    logic        f, l;
    rst_ni = 1'b0; root_we = 1'b0; root_ppn = '0; req_valid = 1'b0;
    req_vaddr = '0; rsp_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(req_ready && !mem_req_valid && !rsp_valid, "R1 reset outputs",
        {29'b0, req_ready, mem_req_valid, rsp_valid}, 32'h4);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(req_ready && !mem_req_valid && !rsp_valid, "R1 after release",
        {29'b0, req_ready, mem_req_valid, rsp_valid}, 32'h4);

    // vector table walk
    for (int v = 0; v < NV; v++) begin
      vec_t t = VEC_TBL[v];
      int exp_rd = (t.fault && !t.lvl) ? 1 : 2;
      set_root(t.root);
      load_tables(t.root, t.va, t.dir_e, t.tbl_e);
      walk(t.va, 0, 0, '0, pa, f, l);
      chk(f == t.fault, "R4/R5/R6 fault flag", {31'b0, f}, {31'b0, t.fault});
      if (t.fault) chk(l == t.lvl, t.lvl ? "R6 fault level" : "R5 fault level", {31'b0, l}, {31'b0, t.lvl});
      else chk(pa == t.pa, "R4 physical address", pa, t.pa);
      chk(rd_cnt == exp_rd, "R5/R6 read count", rd_cnt, exp_rd);
      chk(rd_addr[0] == dir_addr(t.root, t.va), "R2 directory address", rd_addr[0], dir_addr(t.root, t.va));
      if (exp_rd == 2)
        chk(rd_addr[1] == tbl_addr(t.dir_e, t.va), "R3 table address", rd_addr[1], tbl_addr(t.dir_e, t.va));
    end

    // R9/R10: stalled memory port, long latency, held response
    mem_stall = 3; mem_lat = 5;
    set_root(VEC_TBL[0].root);
    load_tables(VEC_TBL[0].root, VEC_TBL[0].va, VEC_TBL[0].dir_e, VEC_TBL[0].tbl_e);
    walk(VEC_TBL[0].va, 3, 0, '0, pa, f, l);
    chk(pa == VEC_TBL[0].pa && !f, "R9 stalled walk result", pa, VEC_TBL[0].pa);
    chk(rd_addr[1] == tbl_addr(VEC_TBL[0].dir_e, VEC_TBL[0].va), "R9 table address under stall",
        rd_addr[1], tbl_addr(VEC_TBL[0].dir_e, VEC_TBL[0].va));

    // R7: root write in the acceptance cycle
    mem_stall = 0; mem_lat = 2;
    set_root(32'h0001_0000);
    load_tables(32'h0001_0000, 32'h1234_5678, 32'h0002_0001, 32'hABCD_E003);
    walk(32'h1234_5678, 0, 1, 32'h0009_0000, pa, f, l);
    chk(rd_addr[0] == dir_addr(32'h0001_0000, 32'h1234_5678), "R7 same-cycle write ignored",
        rd_addr[0], dir_addr(32'h0001_0000, 32'h1234_5678));
    chk(pa == 32'hABCD_E678, "R7 same-cycle walk result", pa, 32'hABCD_E678);
    load_tables(32'h0009_0000, 32'h1234_5678, 32'h0002_0001, 32'hABCD_E003);
    walk(32'h1234_5678, 0, 0, '0, pa, f, l);
    chk(rd_addr[0] == dir_addr(32'h0009_0000, 32'h1234_5678), "R7 new root on next walk",
        rd_addr[0], dir_addr(32'h0009_0000, 32'h1234_5678));

    // R7: root write mid-walk with a stalled port
    mem_stall = 2; mem_lat = 3;
    load_tables(32'h0009_0000, 32'h0040_1000, 32'h0000_5000, 32'h0);
    walk(32'h0040_1000, 0, 2, 32'h000A_0000, pa, f, l);
    chk(rd_addr[0] == dir_addr(32'h0009_0000, 32'h0040_1000), "R7 mid-walk write ignored",
        rd_addr[0], dir_addr(32'h0009_0000, 32'h0040_1000));
    chk(f && !l, "R5 fault after mid-walk write", {30'b0, f, l}, 32'h2);

    // R1: reset in the middle of a walk
    mem_stall = 0; mem_lat = 6;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = 32'h1234_5678;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    chk(req_ready && !mem_req_valid && !rsp_valid, "R1 reset mid-walk",
        {29'b0, req_ready, mem_req_valid, rsp_valid}, 32'h4);
    rst_ni = 1'b1;
    repeat (20) @(negedge clk);
    chk(req_ready && !rsp_valid, "R1 stays idle after reset",
        {30'b0, req_ready, rsp_valid}, 32'h2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule